// File: doc/BRIEF.md
# Floating-Point Operand Compare and Swap

This combinational block sits at the front of a floating-point adder. It receives two single-precision operands, each already split into a sign, an 8-bit biased exponent and a 24-bit mantissa that includes the hidden leading one. It decides which operand has the larger magnitude and sends that operand, unchanged, to the "big" outputs. The other operand goes to the "small" outputs, ready for an alignment shifter placed downstream.

Ordering is decided by exponent first. When the exponents are equal, it is decided by mantissa. Two parallel magnitude comparators evaluate both orderings at the same time, and a final multiplexer picks which one controls the swap. Alongside the routed operands, the block reports four more things:
- the result exponent;
- the non-negative exponent difference, which the aligner uses as its right-shift amount;
- a swap flag;
- an equal-exponent flag that marks the case where no alignment shift is needed.

Top module: `fpcs_order`

## Requirements
- R1: When one operand's exponent is strictly larger, that operand's sign and mantissa appear unchanged on `big_sign`/`big_man`, and the other operand's sign and mantissa appear on `small_sign`/`small_man`.
- R2: When the exponents are equal, the operand with the strictly larger mantissa (compared as an unsigned 24-bit value) is routed to the big outputs.
- R3: `swapped` is 1 exactly when operand B has been routed to the big outputs, and 0 when operand A has.
- R4: `shift_amt` equals the big operand's exponent minus the small operand's exponent, as an unsigned 8-bit value that is never negative.
- R5: `res_exp` always equals the larger of the two input exponents.
- R6: `exp_same` is 1 exactly when the two exponents are equal, which is also exactly when `shift_amt` is 0.
- R7: When both the exponents and the mantissas are equal, operand A is reported as the larger and `swapped` is 0, whatever the signs are.
- R8: The signs take no part in the ordering. Flipping either input sign changes only the sign outputs, which follow their own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_sign | input | 1 | Sign of operand A |
| a_exp | input | 8 | Biased exponent of operand A |
| a_man | input | 24 | Mantissa of operand A, hidden bit included |
| b_sign | input | 1 | Sign of operand B |
| b_exp | input | 8 | Biased exponent of operand B |
| b_man | input | 24 | Mantissa of operand B, hidden bit included |
| big_sign | output | 1 | Sign of the larger-magnitude operand |
| big_man | output | 24 | Mantissa of the larger-magnitude operand |
| small_sign | output | 1 | Sign of the other operand |
| small_man | output | 24 | Mantissa of the other operand, still unshifted |
| res_exp | output | 8 | Result exponent, equal to the larger exponent |
| shift_amt | output | 8 | Exponent difference, used as the alignment shift amount |
| swapped | output | 1 | 1 when operand B was chosen as the larger |
| exp_same | output | 1 | 1 when the exponents are equal and no shift is needed |

## Verification
The assertions assume that every input bit is driven to 0 or 1; they are skipped while any input is unknown. They also assume that the two operands are independent of each other, with any exponent pair allowed, including the extremes 0 and 255. The stimulus drives every input in the same step, with fully known values, before the outputs are sampled. Random pairs are steered toward equal exponents and equal mantissas often enough that the tie paths get frequent coverage, and not only by chance.

// File: rtl/fpcs_pkg.sv
package fpcs_pkg;
    localparam int EXP_W = 8;
    localparam int MAN_W = 24;

    typedef struct packed {
        logic swap;     // operand B is the larger
        logic exp_tie;  // exponents equal
        logic man_tie;  // mantissas equal
    } fpcs_pick_t;
endpackage

// File: rtl/fpcs_mag_cmp.sv
// Parallel magnitude comparator: per-bit greater/equal terms merged in a
// balanced tree, so depth grows with log2(W) instead of a carry chain.
module fpcs_mag_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic         x_gt,
    output logic         x_eq
);
    localparam int LEVELS = (W > 1) ? $clog2(W) : 0;
    localparam int N      = 1 << LEVELS;

    logic [N-1:0] gt_lv [LEVELS+1];
    logic [N-1:0] eq_lv [LEVELS+1];

    always_comb begin
        for (int lv = 0; lv <= LEVELS; lv++) begin
            gt_lv[lv] = '0;
            eq_lv[lv] = '1;
        end
        for (int i = 0; i < W; i++) begin
            gt_lv[0][i] = x[i] & ~y[i];
            eq_lv[0][i] = ~(x[i] ^ y[i]);
        end
        for (int lv = 0; lv < LEVELS; lv++) begin
            for (int j = 0; j < N / 2; j++) begin
                if (j < (N >> (lv + 1))) begin
                    gt_lv[lv+1][j] = gt_lv[lv][2*j+1]
                                   | (eq_lv[lv][2*j+1] & gt_lv[lv][2*j]);
                    eq_lv[lv+1][j] = eq_lv[lv][2*j+1] & eq_lv[lv][2*j];
                end
            end
        end
    end

    assign x_gt = gt_lv[LEVELS][0];
    assign x_eq = eq_lv[LEVELS][0];

    always_comb begin
        if (!$isunknown({x, y})) begin
            AST_CMP_EXCLUSIVE: assert (!(x_gt && x_eq)); // R6
        end
    end
endmodule

// File: rtl/fpcs_exp_diff.sv
// Both differences are formed in parallel; the swap decision only picks one.
module fpcs_exp_diff #(
    parameter int W = 8
) (
    input  logic [W-1:0] ea,
    input  logic [W-1:0] eb,
    input  logic         b_big,
    output logic [W-1:0] diff
);
    logic [W-1:0] a_minus_b;
    logic [W-1:0] b_minus_a;

    always_comb begin
        a_minus_b = ea - eb;
        b_minus_a = eb - ea;
        diff      = b_big ? b_minus_a : a_minus_b;
    end
endmodule

// File: rtl/fpcs_order.sv
module fpcs_order
    import fpcs_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int MW = MAN_W
) (
    input  logic          a_sign,
    input  logic [EW-1:0] a_exp,
    input  logic [MW-1:0] a_man,
    input  logic          b_sign,
    input  logic [EW-1:0] b_exp,
    input  logic [MW-1:0] b_man,
    output logic          big_sign,
    output logic [MW-1:0] big_man,
    output logic          small_sign,
    output logic [MW-1:0] small_man,
    output logic [EW-1:0] res_exp,
    output logic [EW-1:0] shift_amt,
    output logic          swapped,
    output logic          exp_same
);
    logic       ea_gt, ea_eq;
    logic       ma_gt, ma_eq;
    fpcs_pick_t pick_d;
    logic [EW-1:0] small_exp;

    fpcs_mag_cmp #(.W(EW)) u_exp_cmp (
        .x(a_exp), .y(b_exp), .x_gt(ea_gt), .x_eq(ea_eq)
    );

    fpcs_mag_cmp #(.W(MW)) u_man_cmp (
        .x(a_man), .y(b_man), .x_gt(ma_gt), .x_eq(ma_eq)
    );

    // Final merge: the exponent tie selects which comparison decides.
    always_comb begin
        pick_d.exp_tie = ea_eq;
        pick_d.man_tie = ma_eq;
        if (ea_eq) begin
            pick_d.swap = ~ma_gt & ~ma_eq;   // full tie keeps A as big
        end else begin
            pick_d.swap = ~ea_gt;
        end
    end

    fpcs_exp_diff #(.W(EW)) u_diff (
        .ea(a_exp), .eb(b_exp), .b_big(pick_d.swap), .diff(shift_amt)
    );

    always_comb begin
        swapped    = pick_d.swap;
        exp_same   = pick_d.exp_tie;
        big_sign   = pick_d.swap ? b_sign : a_sign;
        big_man    = pick_d.swap ? b_man  : a_man;
        res_exp    = pick_d.swap ? b_exp  : a_exp;
        small_sign = pick_d.swap ? a_sign : b_sign;
        small_man  = pick_d.swap ? a_man  : b_man;
        small_exp  = pick_d.swap ? a_exp  : b_exp;
    end

    always_comb begin
        if (!$isunknown({a_sign, a_exp, a_man, b_sign, b_exp, b_man})) begin
            AST_BIG_NOT_LESS: assert ({res_exp, big_man} >= {small_exp, small_man}); // R2
            AST_EXP_IS_MAX: assert (res_exp >= a_exp && res_exp >= b_exp); // R5
            AST_SHIFT_SPAN: assert (EW'(small_exp + shift_amt) == res_exp); // R4
            AST_ZERO_SHIFT_FLAG: assert (exp_same == (shift_amt == '0)); // R6
            AST_TIE_KEEPS_A: assert (!(a_exp == b_exp && a_man == b_man) || !swapped); // R7
        end
    end
endmodule

// File: tb/fpcs_order_test.sv
module fpcs_order_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        a_sign, b_sign;
    logic [7:0]  a_exp, b_exp;
    logic [23:0] a_man, b_man;
    logic        big_sign, small_sign, swapped, exp_same;
    logic [23:0] big_man, small_man;
    logic [7:0]  res_exp, shift_amt;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done  = 1'b0;

    fpcs_order uut (
        .a_sign(a_sign), .a_exp(a_exp), .a_man(a_man),
        .b_sign(b_sign), .b_exp(b_exp), .b_man(b_man),
        .big_sign(big_sign), .big_man(big_man),
        .small_sign(small_sign), .small_man(small_man),
        .res_exp(res_exp), .shift_amt(shift_amt),
        .swapped(swapped), .exp_same(exp_same)
    );

    // Reference: B wins only if its exponent is larger, or exponents tie and its mantissa is larger.
    function automatic bit ref_b_wins(input logic [7:0] ea, input logic [23:0] ma,
                                      input logic [7:0] eb, input logic [23:0] mb);
        if (eb > ea) return 1'b1;
        if (eb < ea) return 1'b0;
        return (mb > ma);
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input logic sa, input logic [7:0] ea, input logic [23:0] ma,
                         input logic sb, input logic [7:0] eb, input logic [23:0] mb,
                         input string tag);
        bit bw;
        logic [7:0] mx, mn;
        @(negedge clk);
        a_sign = sa; a_exp = ea; a_man = ma;
        b_sign = sb; b_exp = eb; b_man = mb;
        #1;
        bw = ref_b_wins(ea, ma, eb, mb);
        mx = bw ? eb : ea;
        mn = bw ? ea : eb;
        chk(tag, "R1 big_man",    32'(big_man),    32'(bw ? mb : ma));
        chk(tag, "R1 small_man",  32'(small_man),  32'(bw ? ma : mb));
        chk(tag, "R8 big_sign",   32'(big_sign),   32'(bw ? sb : sa));
        chk(tag, "R8 small_sign", 32'(small_sign), 32'(bw ? sa : sb));
        chk(tag, "R3 swapped",    32'(swapped),    32'(bw));
        chk(tag, "R4 shift_amt",  32'(shift_amt),  32'(mx - mn));
        chk(tag, "R5 res_exp",    32'(res_exp),    32'((ea > eb) ? ea : eb));
        chk(tag, "R6 exp_same",   32'(exp_same),   32'(ea == eb));
    endtask

    initial begin
        while (!done && cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        a_sign = 0; b_sign = 0; a_exp = 0; b_exp = 0; a_man = 0; b_man = 0;
        seed = $urandom(32'h5eed_1234);
        // reset-like idle state: all-zero operands are a full tie
        apply(0, 8'd0,   24'h000000, 0, 8'd0,   24'h000000, "R7 zero");
        apply(0, 8'd127, 24'h800000, 0, 8'd126, 24'h800000, "R1 a_exp_big");
        apply(1, 8'd125, 24'h800000, 0, 8'd127, 24'hC00000, "R1 b_exp_big");
        apply(0, 8'd127, 24'h800000, 0, 8'd127, 24'hC00000, "R2 tie_b_man");
        apply(1, 8'd127, 24'hC00001, 0, 8'd127, 24'hC00000, "R2 tie_a_man");
        apply(0, 8'd255, 24'hFFFFFF, 1, 8'd0,   24'h000000, "R4 max_span");
        apply(0, 8'd0,   24'hFFFFFF, 0, 8'd255, 24'h800000, "R4 max_span_b");
        apply(0, 8'd90,  24'hABCDEF, 1, 8'd90,  24'hABCDEF, "R7 tie_signs");
        apply(1, 8'd90,  24'hABCDEF, 0, 8'd90,  24'hABCDEF, "R7 tie_signs2");
        apply(1, 8'd10,  24'h800000, 1, 8'd11,  24'h800000, "R8 signs");
        apply(0, 8'd10,  24'h800000, 0, 8'd11,  24'h800000, "R8 signs2");
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] ea, eb;
            logic [23:0] ma, mb;
            ea = 8'($urandom);
            eb = ($urandom % 3 == 0) ? ea : 8'($urandom);
            ma = 24'($urandom) | 24'h800000;
            mb = ($urandom % 4 == 0) ? ma : (24'($urandom) | 24'h800000);
            apply(1'($urandom), ea, ma, 1'($urandom), eb, mb, "R2 random");
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule